// File: doc/BRIEF.md
# ADC Power Mode Sequencer

This host-side controller paces conversions on an external sampling converter that offers two low-power states: a light nap and a deep standby. A sample-rate tick asks for one conversion. A two-bit policy input chooses whether the converter stays fully powered, naps between samples, or drops to standby between samples. A reference-source flag tells the controller whether the converter runs from its internal reference or from an external one. The controller drives the nap and standby controls, the active-low convert-start strobe and the active-low read strobe. It also reports when a tick would be served at once.

Before each convert-start, the controller waits out the wake-up interval of the low-power state it is leaving. The length of that interval depends on the reference source. It also waits out a quiet interval after the last read. It then holds convert-start low for a set number of cycles. It waits for the converter's busy line to fall and then rise again, and only then pulses the read strobe.

Every interval is given in nanoseconds as a parameter and turned into a clock-cycle count from a clock-period parameter. Nap with the internal reference is an illegal pairing. It sets a sticky error flag, and the controller then behaves as if the fully powered policy were selected. A tick that cannot be served at once is held pending and is never lost. A tick that arrives while another is still pending increments a saturating overrun counter.

Top module: `adc_pwr_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, nap and standby are low, convert-start and read are high (idle), ready is high, the error flag is low and the overrun count is zero.
- R2: Policy encoding is 2'b00 stay powered, 2'b01 nap between samples, 2'b10 standby between samples, and 2'b11 is treated as stay powered. With a low-power policy and no tick pending, the matching low-power output rises one cycle after the controller returns to idle.
- R3: After nap is released, convert-start falls exactly NAP_CYC+1 cycles later, where NAP_CYC = ceil(NAP_WAKE_NS/CLK_NS).
- R4: After standby is released, convert-start falls exactly SBY_EXT_CYC+1 cycles later if the external reference is selected at release, and SBY_INT_CYC+1 cycles later if the internal one is. No convert-start is issued while nap or standby is high.
- R5: Nap policy with the internal reference (ext_ref low) sets the error flag, which stays set until reset. In that case the controller neither asserts nap nor keeps any low-power state, and it runs as if stay-powered were selected.
- R6: Each convert-start low pulse lasts exactly CNV_CYC = ceil(CNV_PULSE_NS/CLK_NS) cycles.
- R7: The read strobe falls only after busy has been seen low and then high following the last convert-start. It stays low for RD_CYC cycles and is never low while busy is low.
- R8: Convert-start falls no earlier than QUIET_CYC+1 cycles after the read strobe rises, exactly then if a tick is already pending.
- R9: A tick is latched as pending and produces exactly one conversion. A tick that arrives while one is pending and not being started in that cycle increments the overrun counter, which saturates.
- R10: Ready is high exactly when the controller is idle at full power with the quiet interval elapsed; a pending tick is started in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | One-cycle request for a conversion |
| policy | input | 2 | Power policy: 00 powered, 01 nap, 10 standby, 11 powered |
| ext_ref | input | 1 | 1 = external reference, 0 = internal reference |
| busy | input | 1 | Converter busy line, low during a conversion |
| nap_o | output | 1 | Nap control to converter |
| stby_o | output | 1 | Standby control to converter |
| convst_n_o | output | 1 | Active-low convert-start strobe |
| rd_n_o | output | 1 | Active-low read strobe |
| ready_o | output | 1 | A pending tick would start next cycle |
| cfg_err_o | output | 1 | Sticky illegal-configuration flag |
| overrun_cnt_o | output | OVR_W | Saturating count of ticks lost to overrun |

## Verification
The hardest case to reach is a standby wake-up whose latency follows the reference source at the moment of release rather than when standby was entered. To reach it, the stimulus enters standby with the external reference and then switches to the internal reference while the converter is still asleep. The next tick must then take the long internal wake. A second case is the illegal nap pairing arriving while the converter is already in standby. This has to force a wake-up with no tick pending. The bench also stacks two ticks inside one conversion to show a single pending service plus one overrun.

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq #(
  parameter int CLK_NS          = 5,
  parameter int NAP_WAKE_NS     = 300,
  parameter int SBY_WAKE_INT_NS = 500_000_000,
  parameter int SBY_WAKE_EXT_NS = 80_000,
  parameter int QUIET_NS        = 100,
  parameter int CNV_PULSE_NS    = 10,
  parameter int RD_PULSE_NS     = 30,
  parameter int OVR_W           = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_tick,
  input  logic [1:0]       policy,
  input  logic             ext_ref,
  input  logic             busy,
  output logic             nap_o,
  output logic             stby_o,
  output logic             convst_n_o,
  output logic             rd_n_o,
  output logic             ready_o,
  output logic             cfg_err_o,
  output logic [OVR_W-1:0] overrun_cnt_o
);

  function automatic int ns2cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int NAP_CYC     = ns2cyc(NAP_WAKE_NS);
  localparam int SBY_INT_CYC = ns2cyc(SBY_WAKE_INT_NS);
  localparam int SBY_EXT_CYC = ns2cyc(SBY_WAKE_EXT_NS);
  localparam int QUIET_CYC   = ns2cyc(QUIET_NS);
  localparam int CNV_CYC     = ns2cyc(CNV_PULSE_NS);
  localparam int RD_CYC      = ns2cyc(RD_PULSE_NS);

  typedef enum logic [2:0] {S_IDLE, S_SLEEP, S_WAKE, S_CNV, S_WBF, S_WBR, S_RD} st_t;

  st_t             st;
  logic            kind;
  logic [31:0]     cnt;
  logic [31:0]     qcnt;
  logic            pend;
  logic            err;
  logic [OVR_W-1:0] ovr;

  wire illegal  = (policy == 2'b01) && !ext_ref;
  wire eff_sby  = (policy == 2'b10);
  wire eff_lp   = eff_sby || ((policy == 2'b01) && ext_ref);
  wire quiet_ok = (qcnt == 32'(QUIET_CYC));
  wire consume  = (st == S_IDLE) && pend && quiet_ok;
  wire [31:0] wake_len = kind ? (ext_ref ? 32'(SBY_EXT_CYC) : 32'(SBY_INT_CYC))
                              : 32'(NAP_CYC);

  assign nap_o         = (st == S_SLEEP) && !kind;
  assign stby_o        = (st == S_SLEEP) && kind;
  assign convst_n_o    = (st != S_CNV);
  assign rd_n_o        = (st != S_RD);
  assign ready_o       = (st == S_IDLE) && quiet_ok;
  assign cfg_err_o     = err;
  assign overrun_cnt_o = ovr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      kind <= 1'b0;
      cnt  <= '0;
      qcnt <= 32'(QUIET_CYC);
      pend <= 1'b0;
      err  <= 1'b0;
      ovr  <= '0;
    end else begin
      pend <= consume ? sample_tick : (pend | sample_tick);
      if (sample_tick && pend && !consume && (ovr != '1)) ovr <= ovr + 1'b1;
      if (illegal) err <= 1'b1;
      if (st == S_RD) qcnt <= '0;
      else if (!quiet_ok) qcnt <= qcnt + 32'd1;
      case (st)
        S_IDLE:
          if (consume) begin
            st  <= S_CNV;
            cnt <= 32'(CNV_CYC - 1);
          end else if (!pend && eff_lp) begin
            st   <= S_SLEEP;
            kind <= eff_sby;
          end
        S_SLEEP:
          if (pend || !eff_lp || (eff_sby != kind)) begin
            st  <= S_WAKE;
            cnt <= wake_len - 32'd1;
          end
        S_WAKE:
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - 32'd1;
        S_CNV:
          if (cnt == '0) st <= S_WBF;
          else cnt <= cnt - 32'd1;
        S_WBF:
          if (!busy) st <= S_WBR;
        S_WBR:
          if (busy) begin
            st  <= S_RD;
            cnt <= 32'(RD_CYC - 1);
          end
        S_RD:
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - 32'd1;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r4_no_cnv_in_lowpower: assert property (@(posedge clk) disable iff (!rst_n)
    !convst_n_o |-> (!nap_o && !stby_o));

  a_r7_no_read_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_o |-> busy);

  a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !convst_n_o |-> rd_n_o);

  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |=> cfg_err_o);

  a_r5_no_nap_internal_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (nap_o && !ext_ref) |=> !nap_o);

  a_r8_quiet_before_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(convst_n_o) |-> quiet_ok);

  a_r9_overrun_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (overrun_cnt_o >= $past(overrun_cnt_o)));

endmodule

// File: tb/adc_pwr_seq_tb_top.sv
module adc_pwr_seq_tb_top;
  localparam int CLK_NS = 5;
  localparam int NAP_NS = 300, SI_NS = 10_000, SE_NS = 1_000;
  localparam int Q_NS = 100, CV_NS = 10, RD_NS = 30;

  function automatic int to_cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int NC = to_cyc(NAP_NS), SI = to_cyc(SI_NS), SE = to_cyc(SE_NS);
  localparam int QC = to_cyc(Q_NS), CVC = to_cyc(CV_NS), RDC = to_cyc(RD_NS);
  localparam int CONV_LEN = 60;

  logic clk = 0, rst_n = 0, sample_tick = 0, ext_ref = 1, busy = 1;
  logic [1:0] policy = 2'b00;
  logic nap_o, stby_o, convst_n_o, rd_n_o, ready_o, cfg_err_o;
  logic [7:0] overrun_cnt_o;

  always #2.5 clk = ~clk;

  adc_pwr_seq #(.CLK_NS(CLK_NS), .NAP_WAKE_NS(NAP_NS), .SBY_WAKE_INT_NS(SI_NS),
    .SBY_WAKE_EXT_NS(SE_NS), .QUIET_NS(Q_NS), .CNV_PULSE_NS(CV_NS),
    .RD_PULSE_NS(RD_NS), .OVR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .policy(policy),
    .ext_ref(ext_ref), .busy(busy), .nap_o(nap_o), .stby_o(stby_o),
    .convst_n_o(convst_n_o), .rd_n_o(rd_n_o), .ready_o(ready_o),
    .cfg_err_o(cfg_err_o), .overrun_cnt_o(overrun_cnt_o));

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // converter model
  logic cv_prev = 1;
  int dly = 0, bl = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      busy = 1; dly = 0; bl = 0;
    end else if (cv_prev && !convst_n_o) dly = 4;
    else if (dly > 0) begin
      dly--;
      if (dly == 0) begin busy = 0; bl = CONV_LEN; end
    end else if (bl > 0) begin
      bl--;
      if (bl == 0) busy = 1;
    end
    cv_prev = convst_n_o;
  end

  // reference model: phases 0 idle,1 sleep,2 wake,3 start,4 wait-low,5 wait-high,6 read
  int m_ph, m_kind, m_left, m_q, m_pend, m_err, m_ovr;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_kind = 0; m_left = 0; m_q = QC; m_pend = 0; m_err = 0; m_ovr = 0;
    end else begin
      bit lp, ks, qok, go;
      int nph;
      lp  = (policy == 2'b10) || (policy == 2'b01 && ext_ref);
      ks  = (policy == 2'b10);
      qok = (m_q == QC);
      go  = (m_ph == 0) && m_pend && qok;
      nph = m_ph;
      if (m_ph == 0) begin
        if (go) begin nph = 3; m_left = CVC; end
        else if (!m_pend && lp) begin nph = 1; m_kind = ks; end
      end else if (m_ph == 1) begin
        if (m_pend || !lp || (ks != m_kind)) begin
          nph = 2;
          m_left = m_kind ? (ext_ref ? SE : SI) : NC;
        end
      end else if (m_ph == 2 || m_ph == 3 || m_ph == 6) begin
        m_left--;
        if (m_left == 0) nph = (m_ph == 3) ? 4 : 0;
      end else if (m_ph == 4) begin
        if (!busy) nph = 5;
      end else if (m_ph == 5) begin
        if (busy) begin nph = 6; m_left = RDC; end
      end
      if (m_ph == 6) m_q = 0;
      else if (!qok) m_q++;
      if (sample_tick && m_pend && !go && m_ovr < 255) m_ovr++;
      m_pend = go ? sample_tick : (m_pend || sample_tick);
      if (policy == 2'b01 && !ext_ref) m_err = 1;
      m_ph = nph;
    end
  end

  // per-cycle comparison and event tracking
  int cyc = 0, n_conv = 0, n_reads = 0, lp_fall = 0, rd_rise = 0, gap_lp = 0, gap_q = 0;
  logic p_lp = 0, p_rd = 1, p_cv = 1;
  bit saw_low = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      check(nap_o == (m_ph == 1 && m_kind == 0), "R2 nap", nap_o, m_ph == 1 && m_kind == 0);
      check(stby_o == (m_ph == 1 && m_kind == 1), "R2 stby", stby_o, m_ph == 1 && m_kind == 1);
      check(convst_n_o == (m_ph != 3), "R6 convst_n", convst_n_o, m_ph != 3);
      check(rd_n_o == (m_ph != 6), "R7 rd_n", rd_n_o, m_ph != 6);
      check(ready_o == (m_ph == 0 && m_q == QC), "R10 ready", ready_o, m_ph == 0 && m_q == QC);
      check(cfg_err_o == m_err, "R5 cfg_err", cfg_err_o, m_err);
      check(int'(overrun_cnt_o) == m_ovr, "R9 overrun", overrun_cnt_o, m_ovr);
      if (!busy) saw_low = 1;
      if (p_lp && !(nap_o || stby_o)) lp_fall = cyc;
      if (!p_rd && rd_n_o) begin rd_rise = cyc; n_reads++; end
      if (p_rd && !rd_n_o) check(busy && saw_low, "R7 read after busy low-high", busy, 1);
      if (p_cv && !convst_n_o) begin
        n_conv++; gap_lp = cyc - lp_fall; gap_q = cyc - rd_rise; saw_low = 0;
      end
    end
    p_lp = nap_o || stby_o; p_rd = rd_n_o; p_cv = convst_n_o;
  end

  task automatic tick();
    @(negedge clk) sample_tick = 1;
    @(negedge clk) sample_tick = 0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_reads(input int n);
    while (n_reads < n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    wait_cyc(20000);
    check(0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    wait_cyc(3);
    // R1 reset state while in reset
    check(!nap_o && !stby_o && convst_n_o && rd_n_o, "R1 strobes idle", convst_n_o, 1);
    check(ready_o && !cfg_err_o && overrun_cnt_o == 0, "R1 status", ready_o, 1);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    check(ready_o && convst_n_o && overrun_cnt_o == 0, "R1 after release", ready_o, 1);

    // powered policy, stacked ticks
    tick();
    while (n_conv < 1) @(negedge clk);
    check(!ready_o, "R10 not ready during conversion", ready_o, 0);
    tick();
    tick();
    wait_reads(2);
    check(gap_q == QC + 1, "R8 quiet gap", gap_q, QC + 1);
    check(overrun_cnt_o == 1, "R9 one overrun", overrun_cnt_o, 1);
    wait_cyc(200);
    check(n_conv == 2, "R9 single service", n_conv, 2);
    check(ready_o, "R10 ready when idle", ready_o, 1);

    // nap with external reference
    policy = 2'b01;
    wait_cyc(5);
    check(nap_o, "R2 nap asserted", nap_o, 1);
    tick();
    wait_reads(3);
    check(gap_lp == NC + 1, "R3 nap wake", gap_lp, NC + 1);
    wait_cyc(3);
    check(nap_o, "R2 nap reasserted", nap_o, 1);

    // standby, external then internal reference
    policy = 2'b10;
    wait_cyc(NC + 20);
    check(stby_o, "R2 standby asserted", stby_o, 1);
    tick();
    wait_reads(4);
    check(gap_lp == SE + 1, "R4 standby ext wake", gap_lp, SE + 1);
    wait_cyc(5);
    ext_ref = 0;
    wait_cyc(5);
    tick();
    wait_reads(5);
    check(gap_lp == SI + 1, "R4 standby int wake", gap_lp, SI + 1);

    // illegal nap + internal reference
    wait_cyc(5);
    policy = 2'b01;
    wait_cyc(SI + 30);
    check(cfg_err_o, "R5 error set", cfg_err_o, 1);
    check(!nap_o && !stby_o, "R5 stays powered", nap_o, 0);
    check(ready_o, "R10 ready in fallback", ready_o, 1);
    tick();
    wait_reads(6);
    check(n_conv == 6, "R5 conversion at full power", n_conv, 6);
    policy = 2'b11; ext_ref = 1;
    wait_cyc(50);
    check(cfg_err_o, "R5 error sticky", cfg_err_o, 1);
    check(!nap_o && !stby_o, "R2 code 11 powered", stby_o, 0);
    finish_run();
  end
endmodule